// File: doc/BRIEF.md
# Receive System Timing Generator

This block produces the system-side receive timing for one T1 link when the receive side owns the clock. It follows a 193-bit frame made of one framing bit and then 24 channels of eight bits. From two strobes that mark the rising and the falling half of each 1.544 MHz bit, it produces four things. The first is a bit clock enable, which is deasserted where the clock is to be gapped. The second is a frame pulse, and the third is a data/signaling update strobe. The fourth is the current slot position.

The frame pulse can mark every framing bit, the first framing bit of each multiframe, every second framing bit, or the first framing bit of every second multiframe. Its polarity is selectable. The edge that updates the pulse is chosen separately from the edge that updates the data, so the pulse can lead the data by half a bit. In fractional mode the clock enable is removed for masked channels, for the eighth bit of every channel (56k option) and for the framing bit.

Top module: `rx_sys_timing`

## Requirements
- R1: While and after reset, before any bit strobe, `sck_gate_o` is 0, `data_upd_o` and `sig_upd_o` are 0, and the frame pulse is inactive (`fs_o` equals `fs_inv_i`).
- R2: Each `rise_i` strobe advances the slot. `chan_o` is 0 for the framing bit and 1..24 for the channels, and `bit_o` is 0..7, where 7 is bit 8. A frame is 193 bits long. The first `rise_i` after reset enters the framing bit of frame 0, which is the first frame of a multiframe.
- R3: With `frac_i`=0, `sck_gate_o` is 1 for every bit.
- R4: With `frac_i`=1, `sck_gate_o` is 0 for the whole of channel n when `gap_mask_i[n-1]` is 1.
- R5: With `frac_i`=1 and `g56_i`=1, `sck_gate_o` is 0 during bit 8 (`bit_o`=7) of every channel.
- R6: With `frac_i`=1 and `fgap_i`=1, `sck_gate_o` is 0 during the framing bit.
- R7: `data_upd_o` and `sig_upd_o` pulse together for one clock. The pulse comes in the clock after the strobe chosen by `de_fall_i` (0 = `rise_i`, 1 = `fall_i`), and only for bits whose clock enable is 1.
- R8: The frame pulse is active for one bit period and is updated on the strobe chosen by `fe_fall_i`. When `fe_fall_i` equals `de_fall_i`, the pulse covers the framing bit's data interval. When they differ, the pulse starts half a bit before the framing bit's data strobe.
- R9: `fs_mode_i` selects which frames are marked: 0 marks every frame, 1 marks the first frame of each multiframe, 2 marks even frames, and 3 marks the first frame of every even-numbered multiframe. A multiframe is 12 frames with `esf_i`=0 and 24 frames with `esf_i`=1.
- R10: With `esf_i`=1, `fs_mode_i` 2 and 3 behave as 0 and 1.
- R11: `fs_inv_i`=1 makes the frame pulse active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rise_i | input | 1 | Rising-half strobe of the bit clock |
| fall_i | input | 1 | Falling-half strobe of the bit clock |
| fe_fall_i | input | 1 | Frame pulse updates on fall strobe when 1 |
| de_fall_i | input | 1 | Data updates on fall strobe when 1 |
| fs_mode_i | input | 2 | Frame pulse marking mode |
| esf_i | input | 1 | 24-frame multiframe when 1, 12 when 0 |
| fs_inv_i | input | 1 | Frame pulse active low when 1 |
| frac_i | input | 1 | Fractional (gapped) mode |
| gap_mask_i | input | N_CH | Per-channel gap select |
| g56_i | input | 1 | Gap bit 8 of each channel |
| fgap_i | input | 1 | Gap the framing bit |
| sck_gate_o | output | 1 | Bit clock enable for the current bit |
| fs_o | output | 1 | Frame pulse |
| data_upd_o | output | 1 | Data update strobe |
| sig_upd_o | output | 1 | Signaling update strobe |
| chan_o | output | $clog2(N_CH+1) | Current slot: 0 = framing bit |
| bit_o | output | $clog2(BPC) | Bit within channel |

## Verification
The bench uses the default parameters: 24 channels of 8 bits, with 12- and 24-frame multiframes. With these values a run of 26 frames passes the second multiframe boundary in both formats. That reaches the every-second-multiframe marking and its ESF fallback, and also the wrap of the multiframe parity. All four combinations of the frame and data edges are driven, so the half-bit lead appears on both strobe phases. The fractional runs combine a sparse channel mask with the 56k and framing-bit gaps.

// File: rtl/rx_tim_pkg.sv
package rx_tim_pkg;
  localparam logic [1:0] FS_EVERY  = 2'd0;
  localparam logic [1:0] FS_MF     = 2'd1;
  localparam logic [1:0] FS_ALT    = 2'd2;
  localparam logic [1:0] FS_ALT_MF = 2'd3;

  // ESF folds alternate modes onto their plain counterparts
  function automatic logic fs_mark(logic [1:0] mode, logic esf, logic frm_zero,
                                   logic frm_odd, logic mf_odd);
    logic [1:0] m;
    m = (esf && mode[1]) ? {1'b0, mode[0]} : mode;
    case (m)
      FS_EVERY: return 1'b1;
      FS_MF:    return frm_zero;
      FS_ALT:   return !frm_odd;
      default:  return frm_zero & !mf_odd;
    endcase
  endfunction
endpackage

// File: rtl/rx_pos_cnt.sv
module rx_pos_cnt #(
  parameter int N_CH = 24,
  parameter int BPC  = 8,
  localparam int CW  = $clog2(N_CH),
  localparam int BW  = $clog2(BPC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic          cur_f_o,
  output logic [CW-1:0] cur_ch_o,
  output logic [BW-1:0] cur_bt_o,
  output logic          nxt_f_o,
  output logic [CW-1:0] nxt_ch_o,
  output logic [BW-1:0] nxt_bt_o,
  output logic          last_o
);
  logic          f_q;
  logic [CW-1:0] ch_q;
  logic [BW-1:0] bt_q;
  logic          ch_end, bt_end;

  assign ch_end = (ch_q == CW'(N_CH - 1));
  assign bt_end = (bt_q == BW'(BPC - 1));
  assign last_o = !f_q && ch_end && bt_end;

  always_comb begin
    nxt_f_o  = 1'b0;
    nxt_ch_o = ch_q;
    nxt_bt_o = bt_q + BW'(1);
    if (f_q) begin
      nxt_ch_o = '0;
      nxt_bt_o = '0;
    end else if (bt_end) begin
      nxt_bt_o = '0;
      if (ch_end) begin
        nxt_f_o  = 1'b1;
        nxt_ch_o = '0;
      end else begin
        nxt_ch_o = ch_q + CW'(1);
      end
    end
  end

  // reset parks on the last bit so the first advance enters the F-bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q  <= 1'b0;
      ch_q <= CW'(N_CH - 1);
      bt_q <= BW'(BPC - 1);
    end else if (adv_i) begin
      f_q  <= nxt_f_o;
      ch_q <= nxt_ch_o;
      bt_q <= nxt_bt_o;
    end
  end

  assign cur_f_o  = f_q;
  assign cur_ch_o = ch_q;
  assign cur_bt_o = bt_q;
endmodule

// File: rtl/rx_frm_cnt.sv
module rx_frm_cnt #(
  parameter int SF_LEN  = 12,
  parameter int ESF_LEN = 24,
  localparam int MAXL   = (ESF_LEN > SF_LEN) ? ESF_LEN : SF_LEN,
  localparam int FW     = $clog2(MAXL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          esf_i,
  output logic [FW-1:0] frm_o,
  output logic          mf_odd_o,
  output logic [FW-1:0] frm_nx_o,
  output logic          mf_odd_nx_o
);
  logic [FW-1:0] frm_q;
  logic          mfp_q;
  logic          wrap;

  assign wrap        = frm_q >= (esf_i ? FW'(ESF_LEN - 1) : FW'(SF_LEN - 1));
  assign frm_nx_o    = wrap ? '0 : frm_q + FW'(1);
  assign mf_odd_nx_o = wrap ? !mfp_q : mfp_q;

  // reset sits at the end of an odd multiframe; first advance lands on frame 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q <= FW'(MAXL - 1);
      mfp_q <= 1'b1;
    end else if (adv_i) begin
      frm_q <= frm_nx_o;
      mfp_q <= mf_odd_nx_o;
    end
  end

  assign frm_o    = frm_q;
  assign mf_odd_o = mfp_q;
endmodule

// File: rtl/rx_strobe_gen.sv
module rx_strobe_gen
  import rx_tim_pkg::*;
#(
  parameter int N_CH = 24,
  parameter int BPC  = 8,
  parameter int FW   = 5,
  localparam int CW  = $clog2(N_CH),
  localparam int BW  = $clog2(BPC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            fe_fall_i,
  input  logic            de_fall_i,
  input  logic [1:0]      fs_mode_i,
  input  logic            esf_i,
  input  logic            frac_i,
  input  logic [N_CH-1:0] gap_mask_i,
  input  logic            g56_i,
  input  logic            fgap_i,
  input  logic            cur_f_i,
  input  logic [CW-1:0]   cur_ch_i,
  input  logic [BW-1:0]   cur_bt_i,
  input  logic            nxt_f_i,
  input  logic [CW-1:0]   nxt_ch_i,
  input  logic [BW-1:0]   nxt_bt_i,
  input  logic            last_i,
  input  logic [FW-1:0]   frm_i,
  input  logic            mf_odd_i,
  input  logic [FW-1:0]   frm_nx_i,
  input  logic            mf_odd_nx_i,
  output logic            gate_o,
  output logic            fs_act_o,
  output logic            upd_o
);
  logic gate_cur, gate_nxt, use_nxt, fs_hit, fe_stb, de_stb;
  logic gate_q, fs_q, upd_q;

  function automatic logic slot_on(logic f, logic [CW-1:0] ch, logic [BW-1:0] bt,
                                   logic frac, logic [N_CH-1:0] mask, logic g56, logic fgap);
    if (!frac) return 1'b1;
    if (f) return !fgap;
    return !(mask[ch] || (g56 && bt == BW'(BPC - 1)));
  endfunction

  assign gate_cur = slot_on(cur_f_i, cur_ch_i, cur_bt_i, frac_i, gap_mask_i, g56_i, fgap_i);
  assign gate_nxt = slot_on(nxt_f_i, nxt_ch_i, nxt_bt_i, frac_i, gap_mask_i, g56_i, fgap_i);

  // pulse targets the bit whose data strobe is the next one at or after its own edge
  assign use_nxt = !(fe_fall_i && de_fall_i);
  assign fs_hit  = use_nxt
    ? (last_i  && fs_mark(fs_mode_i, esf_i, frm_nx_i == '0, frm_nx_i[0], mf_odd_nx_i))
    : (cur_f_i && fs_mark(fs_mode_i, esf_i, frm_i == '0, frm_i[0], mf_odd_i));

  assign fe_stb = fe_fall_i ? fall_i : rise_i;
  assign de_stb = de_fall_i ? fall_i : rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      fs_q   <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      if (rise_i) gate_q <= gate_nxt;
      if (fe_stb) fs_q <= fs_hit;
      upd_q <= de_stb && (de_fall_i ? gate_cur : gate_nxt);
    end
  end

  assign gate_o   = gate_q;
  assign fs_act_o = fs_q;
  assign upd_o    = upd_q;
endmodule

// File: rtl/rx_sys_timing.sv
module rx_sys_timing #(
  parameter int N_CH    = 24,
  parameter int BPC     = 8,
  parameter int SF_LEN  = 12,
  parameter int ESF_LEN = 24,
  localparam int CW     = $clog2(N_CH),
  localparam int BW     = $clog2(BPC),
  localparam int CHW    = $clog2(N_CH + 1),
  localparam int MAXL   = (ESF_LEN > SF_LEN) ? ESF_LEN : SF_LEN,
  localparam int FW     = $clog2(MAXL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            fe_fall_i,
  input  logic            de_fall_i,
  input  logic [1:0]      fs_mode_i,
  input  logic            esf_i,
  input  logic            fs_inv_i,
  input  logic            frac_i,
  input  logic [N_CH-1:0] gap_mask_i,
  input  logic            g56_i,
  input  logic            fgap_i,
  output logic            sck_gate_o,
  output logic            fs_o,
  output logic            data_upd_o,
  output logic            sig_upd_o,
  output logic [CHW-1:0]  chan_o,
  output logic [BW-1:0]   bit_o
);
  logic          cur_f, nxt_f, last;
  logic [CW-1:0] cur_ch, nxt_ch;
  logic [BW-1:0] cur_bt, nxt_bt;
  logic [FW-1:0] frm, frm_nx;
  logic          mf_odd, mf_odd_nx;
  logic          fs_act, upd;

  rx_pos_cnt #(.N_CH(N_CH), .BPC(BPC)) u_pos (
    .clk_i, .rst_ni, .adv_i(rise_i),
    .cur_f_o(cur_f), .cur_ch_o(cur_ch), .cur_bt_o(cur_bt),
    .nxt_f_o(nxt_f), .nxt_ch_o(nxt_ch), .nxt_bt_o(nxt_bt), .last_o(last)
  );

  rx_frm_cnt #(.SF_LEN(SF_LEN), .ESF_LEN(ESF_LEN)) u_frm (
    .clk_i, .rst_ni, .adv_i(rise_i && last), .esf_i,
    .frm_o(frm), .mf_odd_o(mf_odd), .frm_nx_o(frm_nx), .mf_odd_nx_o(mf_odd_nx)
  );

  rx_strobe_gen #(.N_CH(N_CH), .BPC(BPC), .FW(FW)) u_stb (
    .clk_i, .rst_ni, .rise_i, .fall_i, .fe_fall_i, .de_fall_i, .fs_mode_i, .esf_i,
    .frac_i, .gap_mask_i, .g56_i, .fgap_i,
    .cur_f_i(cur_f), .cur_ch_i(cur_ch), .cur_bt_i(cur_bt),
    .nxt_f_i(nxt_f), .nxt_ch_i(nxt_ch), .nxt_bt_i(nxt_bt), .last_i(last),
    .frm_i(frm), .mf_odd_i(mf_odd), .frm_nx_i(frm_nx), .mf_odd_nx_i(mf_odd_nx),
    .gate_o(sck_gate_o), .fs_act_o(fs_act), .upd_o(upd)
  );

  assign fs_o       = fs_act ^ fs_inv_i;
  assign data_upd_o = upd;
  assign sig_upd_o  = upd;
  assign chan_o     = cur_f ? '0 : CHW'(cur_ch) + CHW'(1);
  assign bit_o      = cur_f ? '0 : cur_bt;
endmodule

// File: rtl/rx_sys_timing_chk.sv
module rx_sys_timing_chk #(
  parameter int N_CH = 24,
  parameter int BPC  = 8,
  localparam int BW  = $clog2(BPC),
  localparam int CHW = $clog2(N_CH + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           rise_i,
  input logic           fall_i,
  input logic           frac_i,
  input logic           fs_inv_i,
  input logic           sck_gate_o,
  input logic           fs_o,
  input logic           data_upd_o,
  input logic [CHW-1:0] chan_o,
  input logic [BW-1:0]  bit_o
);
  // R3
  full_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rise_i && !frac_i) |-> sck_gate_o);
  // R7
  upd_on_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_upd_o |-> sck_gate_o);
  // R7
  upd_after_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_upd_o |-> $past(rise_i || fall_i));
  // R2
  chan_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_o <= CHW'(N_CH)) && (chan_o != '0 || bit_o == '0));
  // R2
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rise_i) |-> ($stable(chan_o) && $stable(bit_o)));
  // R8
  fs_on_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(fs_o) && $stable(fs_inv_i)) |-> $past(rise_i || fall_i));
endmodule

bind rx_sys_timing rx_sys_timing_chk #(.N_CH(N_CH), .BPC(BPC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise_i), .fall_i(fall_i), .frac_i(frac_i),
  .fs_inv_i(fs_inv_i), .sck_gate_o(sck_gate_o), .fs_o(fs_o), .data_upd_o(data_upd_o),
  .chan_o(chan_o), .bit_o(bit_o)
);

// File: tb/rx_sys_timing_bench.sv
module rx_sys_timing_bench;
  localparam int CLK_P = 10;
  localparam int NCH   = 24;
  localparam int FBITS = 193;

  logic clk = 1'b0, rst_ni = 1'b0, rise = 1'b0, fall = 1'b0;
  logic fe_fall = 1'b0, de_fall = 1'b0, esf = 1'b0, fs_inv = 1'b0;
  logic frac = 1'b0, g56 = 1'b0, fgap = 1'b0;
  logic [1:0] fs_mode = 2'd0;
  logic [NCH-1:0] gmask = '0;
  logic sck_gate, fs, dupd, supd;
  logic [4:0] chan;
  logic [2:0] bitn;

  rx_sys_timing u_rx_sys_timing (
    .clk_i(clk), .rst_ni, .rise_i(rise), .fall_i(fall), .fe_fall_i(fe_fall),
    .de_fall_i(de_fall), .fs_mode_i(fs_mode), .esf_i(esf), .fs_inv_i(fs_inv),
    .frac_i(frac), .gap_mask_i(gmask), .g56_i(g56), .fgap_i(fgap),
    .sck_gate_o(sck_gate), .fs_o(fs), .data_upd_o(dupd), .sig_upd_o(supd),
    .chan_o(chan), .bit_o(bitn)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, kb = 0, upd_cnt = 0;
  int m_pos, m_gate, m_upd, m_fs, a_pos, x_pos, a_gate, x_gate, a_upd, x_upd, a_fs, x_fs;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit marked(int f);
    int len = esf ? 24 : 12;
    int m = fs_mode;
    if (esf && m >= 2) m -= 2;
    case (m)
      0: return 1;
      1: return (f % len) == 0;
      2: return (f % 2) == 0;
      default: return (f % (2 * len)) == 0;
    endcase
  endfunction

  // half-slot h: 2k = first half of bit k, 2k+1 = second half
  function automatic bit fs_exp(int h);
    int off = !fe_fall ? 0 : (de_fall ? 1 : -1);
    int d = h - off;
    int f = d / (2 * FBITS);
    int r = d - f * 2 * FBITS;
    return (r <= 1) && marked(f);
  endfunction

  function automatic bit gate_exp(int p);
    if (!frac) return 1;
    if (p == 0) return !fgap;
    return !(gmask[(p-1)/8] || (g56 && ((p-1) % 8) == 7));
  endfunction

  task automatic note(inout int m, inout int a, inout int x, input int act, input int exp);
    if (act != exp) begin
      if (m == 0) begin a = act; x = exp; end
      m++;
    end
  endtask

  task automatic do_reset(bit fe, bit de, int mode, bit e, bit inv, bit fr,
                          logic [NCH-1:0] mk, bit g5, bit fg);
    @(negedge clk);
    rst_ni = 0; rise = 0; fall = 0;
    fe_fall = fe; de_fall = de; fs_mode = 2'(mode); esf = e; fs_inv = inv;
    frac = fr; gmask = mk; g56 = g5; fgap = fg;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;
    kb = 0; upd_cnt = 0;
    m_pos = 0; m_gate = 0; m_upd = 0; m_fs = 0;
  endtask

  task automatic run_bits(int n);
    for (int i = 0; i < n; i++) begin
      int p = kb % FBITS;
      bit g = gate_exp(p);
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        rise = (c == 0); fall = (c == 4);
        @(posedge clk); #1;
        note(m_upd, a_upd, x_upd, {30'd0, dupd, supd},
             (((c == 0 && !de_fall) || (c == 4 && de_fall)) && g) ? 3 : 0);
        if (dupd && kb >= FBITS && kb < 2 * FBITS) upd_cnt++;
        if (c == 0) begin
          note(m_pos, a_pos, x_pos, {chan, bitn},
               (p == 0) ? 0 : ((((p-1)/8 + 1) << 3) | ((p-1) % 8)));
          note(m_gate, a_gate, x_gate, int'(sck_gate), int'(g));
        end
        if ((c == 0 || c == 4) && kb >= 2)
          note(m_fs, a_fs, x_fs, int'(fs ^ fs_inv), int'(fs_exp(2*kb + c/4)));
      end
      kb++;
    end
    @(negedge clk); rise = 0; fall = 0;
  endtask

  task automatic finish_scn(string rg, string ru, string rf);
    chk(m_pos == 0,  "R2 slot position", a_pos, x_pos);
    chk(m_gate == 0, rg, a_gate, x_gate);
    chk(m_upd == 0,  ru, a_upd, x_upd);
    chk(m_fs == 0,   rf, a_fs, x_fs);
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0, 0, 0, 0, '0, 0, 0);
    repeat (2) @(negedge clk);
    chk(sck_gate == 0, "R1 gate after reset", sck_gate, 0);
    chk(dupd == 0 && supd == 0, "R1 no strobe after reset", {dupd, supd}, 0);
    chk(fs == 0, "R1 pulse inactive", fs, 0);
    do_reset(0, 0, 0, 0, 1, 0, '0, 0, 0);
    @(negedge clk);
    chk(fs == 1, "R1 R11 inverted pulse inactive", fs, 1);
  endtask

  task automatic t_full_basic();
    do_reset(0, 0, 0, 0, 0, 0, '0, 0, 0);
    run_bits(3 * FBITS + 5);
    finish_scn("R3 full gate", "R7 rise data strobe", "R8 R9 every F-bit pulse");
    chk(upd_cnt == FBITS, "R7 updates per full frame", upd_cnt, FBITS);
  endtask

  task automatic t_lead_mf();
    do_reset(1, 0, 1, 0, 1, 0, '0, 0, 0);
    run_bits(26 * FBITS);
    finish_scn("R3 full gate", "R7 rise data strobe", "R8 R9 R11 leading multiframe pulse");
  endtask

  task automatic t_alt_mf();
    do_reset(0, 1, 3, 0, 0, 0, '0, 0, 0);
    run_bits(26 * FBITS);
    finish_scn("R3 full gate", "R7 fall data strobe", "R8 R9 every second multiframe");
  endtask

  task automatic t_esf();
    do_reset(1, 1, 3, 1, 0, 0, '0, 0, 0);
    run_bits(26 * FBITS);
    finish_scn("R3 full gate", "R7 fall data strobe", "R10 R9 R8 ESF fallback");
  endtask

  task automatic t_frac_all();
    int x = 0;
    do_reset(0, 0, 2, 0, 0, 1, 24'h800021, 1, 1);
    run_bits(4 * FBITS);
    finish_scn("R4 R5 R6 gaps", "R7 gapped strobes", "R9 alternate F-bit");
    for (int p = 0; p < FBITS; p++) x += gate_exp(p);
    chk(upd_cnt == x, "R7 R4 R5 R6 updates per gapped frame", upd_cnt, x);
  endtask

  task automatic t_frac_fall();
    do_reset(0, 1, 0, 0, 0, 1, 24'h00F0F0, 0, 0);
    run_bits(2 * FBITS + 3);
    finish_scn("R4 mask only", "R7 fall strobe gapped", "R8 lead on fall data");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_full_basic();
    t_lead_mf();
    t_alt_mf();
    t_esf();
    t_frac_all();
    t_frac_fall();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule